// File: doc/BRIEF.md
# Address/Data Write Sequencer with Replay

This block drives one write transaction after another, without end. Each round waits for an address event and a data event on two independent paths. The two events may come in either order or in the same cycle. When both have been seen, the block raises a one-cycle write strobe and presents the captured address and data with it. It then holds off for a number of ticks taken from the `latency` input, and after that the next round begins.

A `replay` pulse at any point throws away the round in progress and starts a new one. The round is not resumed.

Control state is held structurally rather than as an encoded state number. Each of the two waits has its own "armed" register. A running flag and a load-and-decrement counter cover the hold-off. Every wait is non-immediate: an event that arrives in the cycle a wait begins is not seen. A wait begins after reset, after a replay cycle, and in the cycle a round ends.

Top module: `wseq_top`

## Requirements
- R1: While and after reset, with no events applied, `wr_en` and `busy` are 0 and `wr_addr` and `wr_data` read 0.
- R2: Address and data may arrive in either order in separate cycles. `wr_en` is 1 only in the cycle the second one arrives. `wr_addr` and `wr_data` then show the captured values. Between the events, `wr_addr` (or `wr_data`) shows the value already held.
- R3: If `addr_vld` and `data_vld` are both 1 in the same waiting cycle, `wr_en` is 1 in that cycle and carries both input values.
- R4: Once an address has been taken in a round, further `addr_vld` pulses in that round do not change the value written. The same holds for data.
- R5: A write with a `latency` value L > 0 makes `busy` 1 for the L cycles that follow. Events during those cycles are ignored and give no write. Events are accepted again in the first cycle after `busy` falls.
- R6: A write with `latency` = 0 leaves `busy` at 0. Events are accepted in the very next cycle, so two writes can come in adjacent cycles.
- R7: In a cycle with `replay` = 1, `wr_en` is 0 even if both events are present. Events in that cycle are not captured. `wr_addr` shows 0 in the next cycle when no address arrives.
- R8: A `replay` clears any address or data already captured. The new round needs both events again.
- R9: A `replay` during the hold-off makes `busy` 0 in the next cycle. Events are accepted from that next cycle on.
- R10: `latency` is sampled in the write cycle only. Changing it during the hold-off does not change the hold-off length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Address event present this cycle |
| addr_val | input | AW | Address carried by the event |
| data_vld | input | 1 | Data event present this cycle |
| data_val | input | DW | Data carried by the event |
| latency | input | LW | Hold-off tick count, sampled in the write cycle |
| replay | input | 1 | Strong abort and restart of the round |
| wr_en | output | 1 | One-cycle write request |
| wr_addr | output | AW | Write address (held or bypassed capture) |
| wr_data | output | DW | Write data (held or bypassed capture) |
| busy | output | 1 | Hold-off countdown running |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the join of the two waits and a strong abort. The bench drives `replay` in a cycle where both events are present. It passes only if no strobe is seen and nothing is captured in that cycle. The second pair is the end of the hold-off and the start of the next round. The bench drives events in the last `busy` cycle and again in the first cycle after it. Only the second of these may produce a write. With zero latency, this also yields two strobes in adjacent cycles.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  // Round phase, exported as a named wire for observation.
  typedef enum logic [1:0] {
    PH_GATHER = 2'd0,
    PH_HOLD   = 2'd1,
    PH_ABORT  = 2'd2
  } wseq_phase_e;

  // A wait branch counts as complete if it was already finished earlier
  // or if its event is taken in this cycle.
  function automatic logic branch_done(input logic armed, input logic hit);
    return (!armed) || hit;
  endfunction

  // The join fires when the gather phase is live, both branches are
  // complete and no abort is present.
  function automatic logic join_fire(input logic a_armed, input logic a_hit,
                                     input logic d_armed, input logic d_hit,
                                     input logic abort);
    return !abort && (a_armed || d_armed)
           && branch_done(a_armed, a_hit) && branch_done(d_armed, d_hit);
  endfunction

endpackage

// File: rtl/wseq_arm.sv
module wseq_arm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         rearm_i,
  input  logic         ev_vld_i,
  input  logic [W-1:0] ev_val_i,
  output logic         armed_o,
  output logic         hit_o,
  output logic [W-1:0] val_o
);

  logic         armed_q;
  logic [W-1:0] cap_q;
  logic         hit;

  // An event counts only while armed and not during an abort.
  assign hit = armed_q && ev_vld_i && !abort_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      cap_q   <= '0;
    end else if (abort_i) begin
      armed_q <= 1'b1;
      cap_q   <= '0;
    end else begin
      if (hit) begin
        armed_q <= 1'b0;
        cap_q   <= ev_val_i;
      end
      if (rearm_i) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign hit_o   = hit;
  assign val_o   = hit ? ev_val_i : cap_q;

endmodule

// File: rtl/wseq_join.sv
module wseq_join (
  input  logic a_armed_i,
  input  logic a_hit_i,
  input  logic d_armed_i,
  input  logic d_hit_i,
  input  logic abort_i,
  output logic fire_o
);
  import wseq_pkg::*;

  always_comb begin
    fire_o = join_fire(a_armed_i, a_hit_i, d_armed_i, d_hit_i, abort_i);
  end

endmodule

// File: rtl/wseq_delay.sv
module wseq_delay #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          fire_i,
  input  logic [LW-1:0] lat_i,
  output logic          busy_o,
  output logic          rearm_o
);

  logic          run_q;
  logic [LW-1:0] cnt_q;

  function automatic logic [LW-1:0] step_down(input logic [LW-1:0] c);
    return c - LW'(1);
  endfunction

  function automatic logic at_last(input logic [LW-1:0] c);
    return c == LW'(1);
  endfunction

  // The round ends either straight after a zero-latency write or on the
  // last tick of the countdown.
  assign rearm_o = !abort_i &&
                   ((fire_i && (lat_i == '0)) || (run_q && at_last(cnt_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (fire_i) begin
      run_q <= (lat_i != '0);
      cnt_q <= lat_i;
    end else if (run_q) begin
      if (at_last(cnt_q)) begin
        run_q <= 1'b0;
      end
      cnt_q <= step_down(cnt_q);
    end
  end

  assign busy_o = run_q;

endmodule

// File: rtl/wseq_top.sv
module wseq_top #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr_val,
  input  logic          data_vld,
  input  logic [DW-1:0] data_val,
  input  logic [LW-1:0] latency,
  input  logic          replay,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic [DW-1:0] wr_data
);
  import wseq_pkg::*;

  // Named internal events.
  logic        a_armed, a_hit;
  logic        d_armed, d_hit;
  logic        fire;
  logic        rearm;
  logic        hold;
  wseq_phase_e phase;

  wseq_arm #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .abort_i(replay), .rearm_i(rearm),
    .ev_vld_i(addr_vld), .ev_val_i(addr_val),
    .armed_o(a_armed), .hit_o(a_hit), .val_o(wr_addr)
  );

  wseq_arm #(.W(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .abort_i(replay), .rearm_i(rearm),
    .ev_vld_i(data_vld), .ev_val_i(data_val),
    .armed_o(d_armed), .hit_o(d_hit), .val_o(wr_data)
  );

  wseq_join u_join (
    .a_armed_i(a_armed), .a_hit_i(a_hit),
    .d_armed_i(d_armed), .d_hit_i(d_hit),
    .abort_i(replay), .fire_o(fire)
  );

  wseq_delay #(.LW(LW)) u_delay (
    .clk(clk), .rst_n(rst_n), .abort_i(replay), .fire_i(fire),
    .lat_i(latency), .busy_o(hold), .rearm_o(rearm)
  );

  always_comb begin
    if (replay)    phase = PH_ABORT;
    else if (hold) phase = PH_HOLD;
    else           phase = PH_GATHER;
  end

  assign wr_en = fire;
  assign busy  = hold;

endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          replay,
  input logic          wr_en,
  input logic          busy,
  input logic [LW-1:0] latency,
  input logic          a_armed,
  input logic          d_armed
);

  // R7
  abort_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> !wr_en);

  // R5
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && latency != '0) |=> busy);

  // R6
  zero_lat_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && latency == '0) |=> !busy);

  // R9
  abort_drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> !busy);

  // R5
  no_write_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  // R8
  abort_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (a_armed && d_armed));

endmodule

bind wseq_top wseq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .replay(replay), .wr_en(wr_en),
  .busy(busy), .latency(latency), .a_armed(a_armed), .d_armed(d_armed)
);

// File: tb/sim_wseq_top.sv
module sim_wseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_vld, data_vld, replay;
  logic [AW-1:0] addr_val;
  logic [DW-1:0] data_val;
  logic [LW-1:0] latency;
  logic          wr_en, busy;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wseq_top #(.AW(AW), .DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_val(addr_val),
    .data_vld(data_vld), .data_val(data_val), .latency(latency),
    .replay(replay), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
    .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one cycle of inputs after the falling edge; outputs settle 1 unit later.
  task automatic cyc(input bit av, input int a, input bit dv, input int d,
                     input int lat, input bit rp);
    @(negedge clk);
    addr_vld = av; addr_val = AW'(a);
    data_vld = dv; data_val = DW'(d);
    latency  = LW'(lat); replay = rp;
    #1;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  task automatic resync(); cyc(0, 0, 0, 0, 0, 1); endtask

  task automatic t_reset();
    chk(wr_en == 0, "R1 wr_en", wr_en, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wr_addr == 0 && wr_data == 0, "R1 buses", {wr_addr, wr_data}, 0);
  endtask

  task automatic t_order();
    resync();
    cyc(1, 'h11, 0, 0, 0, 0);
    chk(wr_en == 0, "R2 addr first no write", wr_en, 0);
    idle();
    chk(wr_addr == 'h11 && wr_en == 0, "R2 addr held", wr_addr, 'h11);
    cyc(0, 0, 1, 'h22, 0, 0);
    chk(wr_en == 1 && wr_addr == 'h11 && wr_data == 'h22, "R2 write a-then-d",
        {wr_en, wr_addr, wr_data}, {1'b1, 8'h11, 8'h22});
    cyc(0, 0, 1, 'h33, 0, 0);
    chk(wr_en == 0, "R2 data first no write", wr_en, 0);
    cyc(1, 'h44, 0, 0, 0, 0);
    chk(wr_en == 1 && wr_addr == 'h44 && wr_data == 'h33, "R2 write d-then-a",
        {wr_en, wr_addr, wr_data}, {1'b1, 8'h44, 8'h33});
  endtask

  task automatic t_same();
    resync();
    cyc(1, 'h12, 1, 'h34, 0, 0);
    chk(wr_en == 1 && wr_addr == 'h12 && wr_data == 'h34, "R3 joint write",
        {wr_en, wr_addr, wr_data}, {1'b1, 8'h12, 8'h34});
  endtask

  task automatic t_repeat();
    resync();
    cyc(1, 'h55, 0, 0, 0, 0);
    cyc(1, 'h66, 0, 0, 0, 0);
    chk(wr_en == 0 && wr_addr == 'h55, "R4 second addr ignored", wr_addr, 'h55);
    cyc(0, 0, 1, 'h77, 0, 0);
    chk(wr_en == 1 && wr_addr == 'h55 && wr_data == 'h77, "R4 first addr written",
        {wr_en, wr_addr, wr_data}, {1'b1, 8'h55, 8'h77});
  endtask

  task automatic t_hold();
    resync();
    cyc(1, 'hA1, 1, 'hB1, 3, 0);
    chk(wr_en == 1, "R5 write", wr_en, 1);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 'hC0 + i, 1, 'hD0 + i, 7, 0);   // latency changed: R10
      chk(busy == 1, "R5 busy during hold", busy, 1);
      chk(wr_en == 0, "R5 events ignored in hold", wr_en, 0);
    end
    cyc(1, 'hE1, 1, 'hF1, 0, 0);
    chk(busy == 0, "R10 hold length fixed at write", busy, 0);
    chk(wr_en == 1 && wr_addr == 'hE1, "R5 events accepted after hold",
        {wr_en, wr_addr}, {1'b1, 8'hE1});
    cyc(1, 'h21, 1, 'h31, 0, 0);
    chk(busy == 0, "R6 no hold at zero latency", busy, 0);
    chk(wr_en == 1 && wr_data == 'h31, "R6 adjacent write",
        {wr_en, wr_data}, {1'b1, 8'h31});
  endtask

  task automatic t_abort();
    resync();
    cyc(1, 'h5A, 1, 'h5B, 0, 1);
    chk(wr_en == 0, "R7 no write with replay", wr_en, 1'b0);
    idle();
    chk(wr_en == 0 && wr_addr == 0, "R7 replay-cycle events dropped",
        {wr_en, wr_addr}, 0);
    cyc(1, 'h61, 1, 'h62, 0, 0);
    chk(wr_en == 1, "R7 write after replay", wr_en, 1);
  endtask

  task automatic t_clear();
    resync();
    cyc(1, 'h99, 0, 0, 0, 0);
    resync();
    idle();
    chk(wr_addr == 0, "R8 capture cleared", wr_addr, 0);
    cyc(0, 0, 1, 'hAA, 0, 0);
    chk(wr_en == 0, "R8 address needed again", wr_en, 0);
    cyc(1, 'hBB, 0, 0, 0, 0);
    chk(wr_en == 1 && wr_addr == 'hBB && wr_data == 'hAA, "R8 new round write",
        {wr_en, wr_addr, wr_data}, {1'b1, 8'hBB, 8'hAA});
  endtask

  task automatic t_abort_hold();
    resync();
    cyc(1, 'h10, 1, 'h20, 5, 0);
    idle();
    idle();
    chk(busy == 1, "R9 busy before replay", busy, 1);
    resync();
    cyc(1, 'h30, 1, 'h40, 0, 0);
    chk(busy == 0, "R9 busy dropped", busy, 0);
    chk(wr_en == 1 && wr_addr == 'h30, "R9 events accepted after replay",
        {wr_en, wr_addr}, {1'b1, 8'h30});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr_vld = 0; addr_val = '0; data_vld = 0; data_val = '0;
    latency = '0; replay = 0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_order();
    t_same();
    t_repeat();
    t_hold();
    t_abort();
    t_clear();
    t_abort_hold();
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule